// File: doc/BRIEF.md
# Sound-Chip Register Port with Two-Wire Bit-Bang Lines

This block is the processor-facing register interface of a three-channel sound generator. Software picks one of fifteen 8-bit registers by writing an index to a select port. It then writes or reads that register through a data port. Two independent pairs of fully decoded I/O addresses reach the same register file. Tone and noise synthesis sit outside this block. Only storage, addressing, readback and pin behaviour are modelled.

Register 14 is the general-purpose I/O register. It is used as a bit-banged master for a two-wire serial EEPROM bus. Bit 0 controls the data line and bit 1 controls the clock line. Both lines are open-drain: a 0 pulls the line low and a 1 releases it to the external pull-up. Bit 6 of register 7 acts as the port direction. The lines are driven only when that bit is 1.

A read of register 14 returns the synchronized level of the data line in bit 0, not the stored bit. This lets software sample acknowledge and data bits that the slave drives.

Top module: `snd_reg_port`

## Requirements
- R1: When rst_ni is asserted, every register clears to 0x00, the index clears to 0 and both line-pull outputs are 0 (lines released).
- R2: A write (wr_i) to address 0xFFFD or 0x00F5 latches wdata_i[3:0] as the register index; wdata_i[7:4] are ignored.
- R3: A write to address 0xBFFD or 0x00F6 stores wdata_i into the register selected by the current index, visible on the next read.
- R4: A read (rd_i) at address 0xFFFD or 0x00F6 returns the selected register on rdata_o in the same cycle; at any other address, or with rd_i low, rdata_o is 0xFF.
- R5: The address decode uses all 16 bits: writes to any other address (for example 0x7FFD or 0xFFF5) change neither the index nor any register.
- R6: With index 15 selected, data writes are dropped and reads return 0xFF.
- R7: When bit 6 of register 7 is 0, sda_low_o and scl_low_o are both 0, whatever register 14 holds.
- R8: When bit 6 of register 7 is 1, sda_low_o is the inverse of register 14 bit 0 and scl_low_o is the inverse of register 14 bit 1.
- R9: A read of register 14 returns the stored bits 7:1 and, in bit 0, the sda_i level sampled through two clock edges; a pin change shows up on the read after the second rising edge.
- R10: Both address pairs reach one shared index and register file: a value written through one pair reads back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address of the current access |
| wr_i | input | 1 | I/O write strobe, one cycle per write |
| rd_i | input | 1 | I/O read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0xFF when no decoded read |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| scl_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |

## Verification
The following properties are checked on every cycle:
- a select write lands in the index;
- a data write lands in the addressed register;
- a write with index 15 leaves the whole file stable, and a read with index 15 returns 0xFF;
- the lines stay released while the direction bit is clear;
- the synchronized data level trails the pin by two edges.

Only the bench scenarios can show the following:
- aliasing between the two address pairs;
- that near-miss addresses are rejected;
- that upper index bits are masked;
- the exact read cycle in which a slave pulling the line low becomes visible;
- that a mid-run reset clears state the earlier traffic set up.

// File: rtl/snd_port_pkg.sv
package snd_port_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned REG_COUNT = 15;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned IO_REG    = 14;
  localparam int unsigned MIX_REG   = 7;
  localparam int unsigned DIR_BIT   = 6;
  localparam int unsigned SDA_BIT   = 0;
  localparam int unsigned SCL_BIT   = 1;

  typedef struct packed {
    logic sel_wr;
    logic dat_wr;
    logic rd_hit;
  } bus_dec_t;
endpackage

// File: rtl/snd_addr_dec.sv
module snd_addr_dec #(
  parameter logic [15:0] SEL_A = 16'hFFFD,
  parameter logic [15:0] DAT_A = 16'hBFFD,
  parameter logic [15:0] SEL_B = 16'h00F5,
  parameter logic [15:0] DAT_B = 16'h00F6
) (
  input  logic [15:0]              addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  output snd_port_pkg::bus_dec_t   dec_o
);
  logic hit_sel, hit_dat, hit_rd;

  // full 16-bit compare, no partial decode
  assign hit_sel = (addr_i == SEL_A) || (addr_i == SEL_B);
  assign hit_dat = (addr_i == DAT_A) || (addr_i == DAT_B);
  assign hit_rd  = (addr_i == SEL_A) || (addr_i == DAT_B);

  assign dec_o.sel_wr = wr_i & hit_sel;
  assign dec_o.dat_wr = wr_i & hit_dat;
  assign dec_o.rd_hit = rd_i & hit_rd;
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file #(
  parameter int unsigned REG_COUNT = snd_port_pkg::REG_COUNT,
  parameter int unsigned IDX_W     = snd_port_pkg::IDX_W,
  parameter int unsigned DATA_W    = snd_port_pkg::DATA_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               sel_wr_i,
  input  logic                               dat_wr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [IDX_W-1:0]                   idx_o,
  output logic                               idx_valid_o,
  output logic [REG_COUNT-1:0][DATA_W-1:0]   regs_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (sel_wr_i) idx_q <= wdata_i[IDX_W-1:0];
  end

  assign idx_o       = idx_q;
  assign idx_valid_o = (32'(idx_q) < REG_COUNT);

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    logic we;
    assign we = dat_wr_i && (idx_q == IDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[r] <= '0;
      else if (we)  regs_o[r] <= wdata_i;
    end

    // R3
    wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dat_wr_i && idx_q == IDX_W'(r)) |=> (regs_o[r] == $past(wdata_i)));
  end

  // R2
  idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> (idx_q == $past(wdata_i[IDX_W-1:0])));

  // R6
  oor_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !idx_valid_o) |=> $stable(regs_o));
endmodule

// File: rtl/snd_pin_io.sv
module snd_pin_io (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_en_i,
  input  logic sda_bit_i,
  input  logic scl_bit_i,
  input  logic sda_i,
  output logic sda_low_o,
  output logic scl_low_o,
  output logic sda_sync_o
);
  logic [1:0] sync_q;
  logic [1:0] age_q;

  // reset to 1: idle bus level behind the pull-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign sda_sync_o = sync_q[1];
  assign sda_low_o  = out_en_i & ~sda_bit_i;
  assign scl_low_o  = out_en_i & ~scl_bit_i;

  // R9
  sda_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sda_sync_o == $past(sda_i, 2)));
endmodule

// File: rtl/snd_reg_port.sv
module snd_reg_port
  import snd_port_pkg::*;
#(
  parameter logic [15:0] SEL_A = 16'hFFFD,
  parameter logic [15:0] DAT_A = 16'hBFFD,
  parameter logic [15:0] SEL_B = 16'h00F5,
  parameter logic [15:0] DAT_B = 16'h00F6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        sda_i,
  output logic        sda_low_o,
  output logic        scl_low_o
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  bus_dec_t                         dec;
  logic [IDX_W-1:0]                 idx;
  logic                             idx_valid;
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;
  logic [SLOTS-1:0][DATA_W-1:0]     slot;
  logic [DATA_W-1:0]                sel_val;
  logic                             sda_sync;
  logic                             out_en;

  snd_addr_dec #(
    .SEL_A(SEL_A), .DAT_A(DAT_A), .SEL_B(SEL_B), .DAT_B(DAT_B)
  ) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .dec_o  (dec)
  );

  snd_reg_file #(
    .REG_COUNT(REG_COUNT), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_wr_i    (dec.sel_wr),
    .dat_wr_i    (dec.dat_wr),
    .wdata_i     (wdata_i),
    .idx_o       (idx),
    .idx_valid_o (idx_valid),
    .regs_o      (regs)
  );

  assign out_en = regs[MIX_REG][DIR_BIT];

  snd_pin_io u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .out_en_i   (out_en),
    .sda_bit_i  (regs[IO_REG][SDA_BIT]),
    .scl_bit_i  (regs[IO_REG][SCL_BIT]),
    .sda_i      (sda_i),
    .sda_low_o  (sda_low_o),
    .scl_low_o  (scl_low_o),
    .sda_sync_o (sda_sync)
  );

  // pad the file to a power of two; empty slots read as all ones
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < REG_COUNT) begin : g_live
      assign slot[s] = regs[s];
    end else begin : g_void
      assign slot[s] = '1;
    end
  end

  always_comb begin
    sel_val = slot[idx];
    if (idx == IDX_W'(IO_REG)) sel_val[SDA_BIT] = sda_sync;
  end

  assign rdata_o = dec.rd_hit ? sel_val : '1;

  // R6
  oor_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.rd_hit && !idx_valid) |-> (rdata_o == 8'hFF));

  // R7
  released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs[MIX_REG][DIR_BIT] |-> (!sda_low_o && !scl_low_o));
endmodule

// File: tb/snd_reg_port_tb_top.sv
`timescale 1ns/1ps
module snd_reg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        sda_low, scl_low;
  logic        slave_low = 1'b0;
  logic        sda_line;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done  = 1'b0;

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #2.5 clk = ~clk;

  assign sda_line = !(sda_low || slave_low);

  snd_reg_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sda_i(sda_line),
    .sda_low_o(sda_low), .scl_low_o(scl_low)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 17 + 3);
  endfunction

  // monitor: pops expected read data and compares
  initial forever begin
    @(mon_ev);
    if (exp_q.size() != 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_err++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic chk_bit(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #0.5;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> mon_ev;
    #1;
    rd = 1'b0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_bit(sda_low, 1'b0, "R1 sda released in reset");
    chk_bit(scl_low, 1'b0, "R1 scl released in reset");
    rst_ni = 1'b1;
    bus_rd(16'hFFFD, 8'h00, "R1 reg0 after reset");
    bus_rd(16'h00F6, 8'h00, "R1 reg0 via second pair");

    // R3 R10 fill through first pair, read back through second
    for (int i = 0; i < 15; i++) begin
      bus_wr(16'hFFFD, 8'(i));
      bus_wr(16'hBFFD, pat(i));
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      bus_wr(16'h00F5, 8'(i));
      // reg14 bit0 shows the line, released and high
      bus_rd(16'h00F6, (i == 14) ? {pat(i)[7:1], 1'b1} : pat(i), "R10 alias readback");
    end
    // R8 with reg7=0x7A (dir on) and reg14=0xF1
    chk_bit(sda_low, 1'b0, "R8 sda bit 1 released");
    chk_bit(scl_low, 1'b1, "R8 scl bit 0 pulled");

    // R2 upper nibble ignored
    bus_wr(16'hFFFD, 8'hA3);
    bus_rd(16'hFFFD, pat(3), "R2 upper index bits masked");

    // R6 index 15
    bus_wr(16'h00F5, 8'h0F);
    bus_wr(16'hBFFD, 8'h55);
    bus_rd(16'hFFFD, 8'hFF, "R6 read of index 15");
    for (int i = 0; i < 15; i++) begin
      bus_wr(16'hFFFD, 8'(i));
      bus_rd(16'hFFFD, (i == 14) ? {pat(i)[7:1], 1'b1} : pat(i), "R6 file untouched");
    end

    // R5 near-miss addresses
    bus_wr(16'hFFFD, 8'h03);
    bus_wr(16'h7FFD, 8'h99);
    bus_wr(16'hFFF5, 8'h02);
    bus_rd(16'hFFFD, pat(3), "R5 no write or select on alias miss");
    // R4 non-read address and idle read
    bus_rd(16'hBFFD, 8'hFF, "R4 data port A is not a read port");
    @(negedge clk);
    addr = 16'hFFFD; rd = 1'b0;
    #0.5;
    n_chk++;
    if (rdata !== 8'hFF) begin
      n_err++;
      $display("FAIL R4 idle bus: rdata=%02h expected=ff", rdata);
    end

    // R7 direction bit off overrides reg14=0x00
    bus_wr(16'hFFFD, 8'd14);
    bus_wr(16'hBFFD, 8'h00);
    bus_wr(16'hFFFD, 8'd7);
    bus_wr(16'hBFFD, 8'h00);
    @(negedge clk);
    chk_bit(sda_low, 1'b0, "R7 sda released with dir off");
    chk_bit(scl_low, 1'b0, "R7 scl released with dir off");
    bus_wr(16'hBFFD, 8'h40);
    @(negedge clk);
    chk_bit(sda_low, 1'b1, "R8 sda pulled with dir on");
    chk_bit(scl_low, 1'b1, "R8 scl pulled with dir on");

    // R8 individual bits
    bus_wr(16'hFFFD, 8'd14);
    bus_wr(16'hBFFD, 8'h02);
    @(negedge clk);
    chk_bit(sda_low, 1'b1, "R8 sda follows bit0=0");
    chk_bit(scl_low, 1'b0, "R8 scl follows bit1=1");

    // R9 slave pulls data line; two-edge latency
    bus_wr(16'hBFFD, 8'h03);
    repeat (3) @(negedge clk);
    slave_low = 1'b1;
    bus_rd(16'hFFFD, 8'h03, "R9 one edge after pull still high");
    bus_rd(16'hFFFD, 8'h02, "R9 two edges after pull shows low");
    slave_low = 1'b0;
    bus_rd(16'hFFFD, 8'h02, "R9 one edge after release still low");
    bus_rd(16'hFFFD, 8'h03, "R9 two edges after release shows high");

    // R1 mid-run reset
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk_bit(sda_low, 1'b0, "R1 sda released on reset");
    rst_ni = 1'b1;
    bus_rd(16'hFFFD, 8'h00, "R1 index and reg0 cleared");
    bus_wr(16'hFFFD, 8'd14);
    bus_rd(16'hFFFD, 8'h01, "R1 reg14 cleared, line high");
    bus_wr(16'hFFFD, 8'd3);
    bus_rd(16'h00F6, 8'h00, "R1 reg3 cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule